// File: doc/BRIEF.md
# Committed Store Buffer with Load Forwarding

This block sits between a core and a single-port memory. It holds stores the core has already committed, so the core can keep issuing further loads and stores while the earlier stores are still on their way to memory. Buffered stores go out one at a time over a valid/ready request channel. A core load is answered in one of two ways. If a buffered store to the same address exists, its data is returned without touching memory. Otherwise the load reads memory, and that read may overtake older buffered stores.

Two static inputs select the ordering policy. `cfg_pso` picks between draining strictly in commit order and draining by slot index, where a younger store to a different address may reach memory first. `cfg_no_fwd` turns off forwarding: a load that hits a buffered store waits until that store has been written, and then reads memory. A fence input orders accesses around a barrier. One kind holds back later loads until every older store has drained. The other kind keeps stores younger than the barrier from draining before every older store has drained.

Top module: `store_drain_buffer`

## Requirements
- R1: After reset the buffer is empty, `st_ready` and `ld_ready` are high, and `mem_req_valid` is low.
- R2: New stores are accepted while older ones are still undrained. `st_ready` is low exactly when DEPTH stores are held.
- R3: When buffered stores older than a load match its address and forwarding is on (`cfg_no_fwd`=0), `ld_rsp_valid` rises one cycle after the load handshake. It carries the data of the youngest matching store, and no memory read is issued.
- R4: A load whose address matches no buffered store issues its memory read (`mem_req_we`=0) before any still-buffered older store is written. Reads win the memory port over drains.
- R5: With `cfg_pso`=0, stores are written to memory in commit order.
- R6: With `cfg_pso`=1, a new store takes the lowest free slot, and the lowest-numbered slot that is allowed to drain goes next. A younger store in a lower slot therefore reaches memory before older stores to other addresses.
- R7: With `cfg_pso`=1, two stores to the same address still reach memory in commit order, and memory ends up holding the younger value.
- R8: With `cfg_no_fwd`=1, a load matching a buffered store gets no response while that store is buffered. Once the store is written, the load reads memory and returns the stored value.
- R9: A fence with `fence_kind`=0 (write-then-read) holds every later load until all stores accepted up to and including the fence cycle have drained. The load's read then follows those writes.
- R10: A fence with `fence_kind`=1 (write-then-write) keeps any store accepted after the fence cycle from draining until all stores accepted up to and including that cycle have drained, even with `cfg_pso`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pso | input | 1 | 0: drain in commit order, 1: drain by slot index |
| cfg_no_fwd | input | 1 | 1: disable store-to-load forwarding |
| st_valid | input | 1 | Committed store offered |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| fence_valid | input | 1 | Fence request, one cycle |
| fence_kind | input | 1 | 0: write-then-read, 1: write-then-write |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Block can take a load |
| ld_addr | input | ADDR_W | Load address |
| ld_rsp_valid | output | 1 | Load data valid, one cycle |
| ld_rsp_data | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1: write (drain), 0: read (load) |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
A corrupted age relation or dependency mask in this block shows up as writes in the wrong order on the memory channel. It appears at the first drain after the bad entry is allocated, so the bench logs every accepted memory request and compares the sequence against the order the policy dictates. A stale forwarding or fence mask appears as a load response with the wrong data, or one that comes too early or too late. Responses are timed to the cycle, and during stalls the bench watches the memory channel for premature reads.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
   typedef enum logic [1:0] {
      LD_IDLE = 2'd0,
      LD_PEND = 2'd1,
      LD_MEM  = 2'd2
   } ld_state_e;

   typedef enum logic {
      FENCE_WR = 1'b0,
      FENCE_WW = 1'b1
   } fence_kind_e;
endpackage

// File: rtl/sdb_order_track.sv
// Per-slot occupancy, relative age and fence dependencies.
module sdb_order_track #(
   parameter int unsigned DEPTH = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DEPTH-1:0]              alloc_vec,
   input  logic [DEPTH-1:0]              free_vec,
   input  logic [DEPTH-1:0]              dep_in,
   output logic [DEPTH-1:0]              valid_q,
   output logic [DEPTH-1:0][DEPTH-1:0]   older_q,
   output logic [DEPTH-1:0][DEPTH-1:0]   dep_q
);
   logic [DEPTH-1:0] remain;
   assign remain = valid_q & ~free_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= remain | alloc_vec;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            older_q[i] <= '0;
            dep_q[i]   <= '0;
         end else if (alloc_vec[i]) begin
            older_q[i] <= remain;
            dep_q[i]   <= dep_in;
         end else begin
            older_q[i] <= older_q[i] & ~free_vec;
            dep_q[i]   <= dep_q[i] & ~free_vec;
         end
      end
   end
endmodule

// File: rtl/sdb_drain_sel.sv
// Chooses the slot that drains next under the selected policy.
module sdb_drain_sel #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                            pso,
   input  logic [DEPTH-1:0]                valid,
   input  logic [DEPTH-1:0][DEPTH-1:0]     older,
   input  logic [DEPTH-1:0][DEPTH-1:0]     dep,
   input  logic [DEPTH-1:0][ADDR_W-1:0]    addr,
   output logic [DEPTH-1:0]                pick_oh,
   output logic                            pick_any
);
   logic [DEPTH-1:0] same_older;
   logic [DEPTH-1:0] elig;

   for (genvar i = 0; i < DEPTH; i++) begin : g_elig
      always_comb begin
         same_older[i] = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (older[i][j] && (addr[j] == addr[i])) same_older[i] = 1'b1;
         end
      end
      assign elig[i] = valid[i] && (dep[i] == '0) &&
                       (pso ? !same_older[i] : (older[i] == '0));
   end

   always_comb begin
      pick_oh = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (elig[i]) pick_oh = DEPTH'(1) << i;
      end
   end
   assign pick_any = |elig;
endmodule

// File: rtl/sdb_fwd_match.sv
// Finds the youngest buffered store that matches a load address.
module sdb_fwd_match #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [DEPTH-1:0]                cand,
   input  logic [DEPTH-1:0][DEPTH-1:0]     older,
   input  logic [DEPTH-1:0][ADDR_W-1:0]    addr,
   input  logic [ADDR_W-1:0]               ld_addr,
   output logic                            hit,
   output logic [DEPTH-1:0]                young_oh
);
   logic [DEPTH-1:0] match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_match
      assign match[i] = cand[i] && (addr[i] == ld_addr);
      always_comb begin
         young_oh[i] = match[i];
         for (int j = 0; j < DEPTH; j++) begin
            if (match[j] && older[j][i]) young_oh[i] = 1'b0;
         end
      end
   end
   assign hit = |match;
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
   import sdb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pso,
   input  logic              cfg_no_fwd,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              fence_valid,
   input  logic              fence_kind,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_rsp_valid,
   output logic [DATA_W-1:0] ld_rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   localparam logic [DEPTH-1:0] NONE = '0;

   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("store_drain_buffer: DEPTH must lie in 2..32");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("store_drain_buffer: widths must be positive");
   end

   logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr_q;
   logic [DEPTH-1:0][DATA_W-1:0]  slot_data_q;
   logic [DEPTH-1:0]              valid_q;
   logic [DEPTH-1:0][DEPTH-1:0]   older_q;
   logic [DEPTH-1:0][DEPTH-1:0]   dep_q;
   logic [DEPTH-1:0]              free_oh, alloc_vec, free_vec, remain;
   logic [DEPTH-1:0]              pick_oh, young_oh;
   logic [DEPTH-1:0]              wr_mask_q, ww_mask_q, ld_mask_q, dep_in;
   logic                          pick_any, hit, st_fire, drain_fire;
   logic                          blocked, rd_req;
   logic [ADDR_W-1:0]             drain_addr, ld_addr_q;
   logic [DATA_W-1:0]             drain_data, fwd_data;
   ld_state_e                     lstate_q;

   // ---------------- slot allocation ----------------
   always_comb begin
      free_oh = NONE;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) free_oh = DEPTH'(1) << i;
      end
   end

   assign st_ready  = (valid_q != '1);
   assign st_fire   = st_valid && st_ready;
   assign alloc_vec = st_fire ? free_oh : NONE;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (alloc_vec[i]) begin
            slot_addr_q[i] <= st_addr;
            slot_data_q[i] <= st_data;
         end
      end
   end

   // ---------------- fence masks ----------------
   assign drain_fire = mem_req_valid && mem_req_ready && mem_req_we;
   assign free_vec   = drain_fire ? pick_oh : NONE;
   assign remain     = valid_q & ~free_vec;
   assign dep_in     = ww_mask_q & ~free_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_mask_q <= NONE;
         ww_mask_q <= NONE;
      end else begin
         if (fence_valid && (fence_kind == FENCE_WR)) wr_mask_q <= remain | alloc_vec;
         else                                         wr_mask_q <= wr_mask_q & ~free_vec;
         if (fence_valid && (fence_kind == FENCE_WW)) ww_mask_q <= remain | alloc_vec;
         else                                         ww_mask_q <= ww_mask_q & ~free_vec;
      end
   end

   // ---------------- ordering and selection ----------------
   sdb_order_track #(.DEPTH(DEPTH)) i_order (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_vec (alloc_vec),
      .free_vec  (free_vec),
      .dep_in    (dep_in),
      .valid_q   (valid_q),
      .older_q   (older_q),
      .dep_q     (dep_q)
   );

   sdb_drain_sel #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_drain (
      .pso      (cfg_pso),
      .valid    (valid_q),
      .older    (older_q),
      .dep      (dep_q),
      .addr     (slot_addr_q),
      .pick_oh  (pick_oh),
      .pick_any (pick_any)
   );

   sdb_fwd_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_fwd (
      .cand     (ld_mask_q & valid_q),
      .older    (older_q),
      .addr     (slot_addr_q),
      .ld_addr  (ld_addr_q),
      .hit      (hit),
      .young_oh (young_oh)
   );

   always_comb begin
      drain_addr = '0;
      drain_data = '0;
      fwd_data   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (pick_oh[i]) begin
            drain_addr = drain_addr | slot_addr_q[i];
            drain_data = drain_data | slot_data_q[i];
         end
         if (young_oh[i]) fwd_data = fwd_data | slot_data_q[i];
      end
   end

   // ---------------- load path ----------------
   assign ld_ready = (lstate_q == LD_IDLE);
   assign blocked  = (wr_mask_q != NONE) || (hit && cfg_no_fwd);
   assign rd_req   = (lstate_q == LD_PEND) && !blocked && !hit;

   assign mem_req_valid = rd_req || pick_any;
   assign mem_req_we    = !rd_req;
   assign mem_req_addr  = rd_req ? ld_addr_q : drain_addr;
   assign mem_req_wdata = drain_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ld_mask_q <= NONE;
      else if (ld_valid && ld_ready) ld_mask_q <= remain;
      else ld_mask_q <= ld_mask_q & ~free_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lstate_q     <= LD_IDLE;
         ld_addr_q    <= '0;
         ld_rsp_valid <= 1'b0;
         ld_rsp_data  <= '0;
      end else begin
         ld_rsp_valid <= 1'b0;
         case (lstate_q)
            LD_IDLE: if (ld_valid) begin
               ld_addr_q <= ld_addr;
               lstate_q  <= LD_PEND;
            end
            LD_PEND: begin
               if (!blocked && hit) begin
                  ld_rsp_valid <= 1'b1;
                  ld_rsp_data  <= fwd_data;
                  lstate_q     <= LD_IDLE;
               end else if (rd_req && mem_req_ready) begin
                  lstate_q <= LD_MEM;
               end
            end
            LD_MEM: if (mem_rsp_valid) begin
               ld_rsp_valid <= 1'b1;
               ld_rsp_data  <= mem_rsp_data;
               lstate_q     <= LD_IDLE;
            end
            default: lstate_q <= LD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdb_chk.sv
module sdb_chk #(
   parameter int unsigned DEPTH = 4
) (
   input logic clk,
   input logic rst_n,
   input logic st_valid,
   input logic st_ready,
   input logic ld_valid,
   input logic ld_ready,
   input logic ld_rsp_valid,
   input logic mem_req_valid,
   input logic mem_req_ready,
   input logic mem_req_we
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;
   logic          ld_out;
   logic          wr_hs, rd_hs, st_hs;

   assign st_hs = st_valid && st_ready;
   assign wr_hs = mem_req_valid && mem_req_ready && mem_req_we;
   assign rd_hs = mem_req_valid && !mem_req_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         ld_out <= 1'b0;
      end else begin
         cnt <= cnt + CW'(st_hs) - CW'(wr_hs);
         if (ld_valid && ld_ready) ld_out <= 1'b1;
         else if (ld_rsp_valid)    ld_out <= 1'b0;
      end
   end

   a_r2_ready_tracks_space: assert property (@(posedge clk) disable iff (!rst_n)
      st_ready == (cnt != CW'(DEPTH)));
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   a_r1_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !(mem_req_valid && mem_req_we));
   a_r4_read_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hs |-> ld_out);
   a_r3_rsp_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rsp_valid |-> ld_out);
   a_r3_one_load_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_out && !ld_rsp_valid) |-> !ld_ready);
endmodule

bind store_drain_buffer sdb_chk #(.DEPTH(DEPTH)) i_sdb_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .st_valid      (st_valid),
   .st_ready      (st_ready),
   .ld_valid      (ld_valid),
   .ld_ready      (ld_ready),
   .ld_rsp_valid  (ld_rsp_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_we    (mem_req_we)
);

// File: tb/test_store_drain_buffer.sv
`timescale 1ns/1ps
module test_store_drain_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_pso = 1'b0, cfg_no_fwd = 1'b0;
   logic        st_valid = 1'b0, fence_valid = 1'b0, fence_kind = 1'b0, ld_valid = 1'b0;
   logic [7:0]  st_addr = '0, ld_addr = '0;
   logic [15:0] st_data = '0;
   logic        mrdy = 1'b0;
   logic        st_ready, ld_ready, ld_rsp_valid, mem_req_valid, mem_req_we;
   logic [15:0] ld_rsp_data, mem_req_wdata;
   logic [7:0]  mem_req_addr;
   logic        mem_rsp_valid;
   logic [15:0] mem_rsp_data;

   int errors = 0, checks = 0;

   always #2 clk = ~clk;

   store_drain_buffer i_store_drain_buffer (
      .clk(clk), .rst_n(rst_n), .cfg_pso(cfg_pso), .cfg_no_fwd(cfg_no_fwd),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .fence_valid(fence_valid), .fence_kind(fence_kind),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mrdy), .mem_req_we(mem_req_we),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

   function automatic logic [15:0] init_val(int a);
      return 16'((a * 3 + 7) & 16'hFFFF);
   endfunction

   // memory model with request log
   logic [15:0] mem [256];
   logic        lg_we [64];
   logic [7:0]  lg_addr [64];
   logic [15:0] lg_data [64];
   int          lg_n;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
         lg_n          <= 0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
      end else begin
         mem_rsp_valid <= 1'b0;
         if (mem_req_valid && mrdy) begin
            if (lg_n < 64) begin
               lg_we[lg_n]   <= mem_req_we;
               lg_addr[lg_n] <= mem_req_addr;
               lg_data[lg_n] <= mem_req_wdata;
            end
            lg_n <= lg_n + 1;
            if (mem_req_we) mem[mem_req_addr] <= mem_req_wdata;
            else begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= mem[mem_req_addr];
            end
         end
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(bit pso, bit nofwd);
      @(negedge clk);
      rst_n = 1'b0; cfg_pso = pso; cfg_no_fwd = nofwd; mrdy = 1'b0;
      st_valid = 0; ld_valid = 0; fence_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push(logic [7:0] a, logic [15:0] d, string req);
      check(st_ready == 1'b1, req, "st_ready before push", int'(st_ready), 1);
      st_valid = 1'b1; st_addr = a; st_data = d;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic fence(logic kind);
      fence_valid = 1'b1; fence_kind = kind;
      @(negedge clk);
      fence_valid = 1'b0;
   endtask

   task automatic drain_one();
      mrdy = 1'b1;
      @(negedge clk);
      mrdy = 1'b0;
   endtask

   task automatic issue_load(logic [7:0] a);
      ld_valid = 1'b1; ld_addr = a;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic wait_rsp(int limit, output bit got, output logic [15:0] d, output int n);
      got = 0; d = '0; n = 0;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if (ld_rsp_valid) begin
            got = 1; d = ld_rsp_data; n = k;
            return;
         end
      end
   endtask

   task automatic chk_log(int idx, logic we, logic [7:0] a, logic [15:0] d, string req);
      check(lg_n > idx, req, $sformatf("log length for entry %0d", idx), lg_n, idx + 1);
      if (lg_n > idx) begin
         check(lg_we[idx] == we, req, $sformatf("entry %0d kind", idx), int'(lg_we[idx]), int'(we));
         check(lg_addr[idx] == a, req, $sformatf("entry %0d addr", idx), int'(lg_addr[idx]), int'(a));
         if (we)
            check(lg_data[idx] == d, req, $sformatf("entry %0d data", idx), int'(lg_data[idx]), int'(d));
      end
   endtask

   // drain order sweep: four stores fill the buffer, one drains, a fifth arrives
   task automatic order_sweep(bit pso);
      logic [7:0]  a [5];
      logic [15:0] d [5];
      int          exp_order [5];
      string       rq;
      rq = pso ? "R6" : "R5";
      do_reset(pso, 1'b0);
      for (int i = 0; i < 5; i++) begin
         a[i] = 8'(8'h80 + i);
         d[i] = 16'(16'h1000 * (i + 1) + i);
      end
      for (int i = 0; i < 4; i++) push(a[i], d[i], "R2");
      check(st_ready == 1'b0, "R2", "st_ready when full", int'(st_ready), 0);
      drain_one();
      push(a[4], d[4], "R2");
      mrdy = 1'b1;
      repeat (8) @(negedge clk);
      mrdy = 1'b0;
      if (pso) begin
         exp_order = '{0, 4, 1, 2, 3};
      end else begin
         exp_order = '{0, 1, 2, 3, 4};
      end
      for (int i = 0; i < 5; i++) chk_log(i, 1'b1, a[exp_order[i]], d[exp_order[i]], rq);
   endtask

   bit          got;
   logic [15:0] rd;
   int          n;

   initial begin
      // R1 reset state
      do_reset(1'b0, 1'b0);
      check(st_ready == 1'b1, "R1", "st_ready after reset", int'(st_ready), 1);
      check(ld_ready == 1'b1, "R1", "ld_ready after reset", int'(ld_ready), 1);
      check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", int'(mem_req_valid), 0);

      // R3 youngest forwarding, no memory read
      do_reset(1'b0, 1'b0);
      push(8'h10, 16'h1111, "R2");
      push(8'h11, 16'h3333, "R2");
      push(8'h10, 16'h2222, "R2");
      issue_load(8'h10);
      wait_rsp(10, got, rd, n);
      check(got, "R3", "forward response seen", int'(got), 1);
      check(n == 1, "R3", "forward latency", n, 1);
      check(rd == 16'h2222, "R3", "forwarded data", int'(rd), 16'h2222);
      mrdy = 1'b1;
      repeat (6) @(negedge clk);
      mrdy = 1'b0;
      check(lg_n == 3, "R3", "requests after drain (no read)", lg_n, 3);
      for (int i = 0; i < 3; i++)
         check(lg_n > i && lg_we[i] == 1'b1, "R3", $sformatf("entry %0d is a write", i), int'(lg_we[i]), 1);

      // R4 miss load overtakes older stores
      do_reset(1'b0, 1'b0);
      push(8'h70, 16'h7070, "R2");
      push(8'h71, 16'h7171, "R2");
      issue_load(8'h72);
      mrdy = 1'b1;
      wait_rsp(10, got, rd, n);
      check(got, "R4", "miss response seen", int'(got), 1);
      check(rd == init_val(8'h72), "R4", "miss data", int'(rd), int'(init_val(8'h72)));
      repeat (4) @(negedge clk);
      mrdy = 1'b0;
      chk_log(0, 1'b0, 8'h72, 16'h0, "R4");
      chk_log(1, 1'b1, 8'h70, 16'h7070, "R4");
      chk_log(2, 1'b1, 8'h71, 16'h7171, "R4");

      // R5 / R6 drain order sweeps
      order_sweep(1'b0);
      order_sweep(1'b1);

      // R7 same-address order in out-of-order mode
      do_reset(1'b1, 1'b0);
      push(8'h90, 16'h1000, "R2");
      push(8'h91, 16'h2000, "R2");
      drain_one();
      push(8'h91, 16'h3000, "R2");
      mrdy = 1'b1;
      repeat (6) @(negedge clk);
      chk_log(0, 1'b1, 8'h90, 16'h1000, "R7");
      chk_log(1, 1'b1, 8'h91, 16'h2000, "R7");
      chk_log(2, 1'b1, 8'h91, 16'h3000, "R7");
      issue_load(8'h91);
      wait_rsp(10, got, rd, n);
      check(got && rd == 16'h3000, "R7", "final memory value", int'(rd), 16'h3000);
      mrdy = 1'b0;

      // R8 no-forward stall
      do_reset(1'b0, 1'b1);
      push(8'hA0, 16'h5A5A, "R2");
      issue_load(8'hA0);
      wait_rsp(6, got, rd, n);
      check(!got, "R8", "no response while store buffered", int'(got), 0);
      check(lg_n == 0, "R8", "no request while stalled", lg_n, 0);
      mrdy = 1'b1;
      wait_rsp(20, got, rd, n);
      check(got && rd == 16'h5A5A, "R8", "data after drain", int'(rd), 16'h5A5A);
      mrdy = 1'b0;
      chk_log(0, 1'b1, 8'hA0, 16'h5A5A, "R8");
      chk_log(1, 1'b0, 8'hA0, 16'h0, "R8");

      // R9 write-then-read fence
      do_reset(1'b0, 1'b0);
      push(8'hB0, 16'h7777, "R2");
      fence(1'b0);
      issue_load(8'hB1);
      wait_rsp(6, got, rd, n);
      check(!got, "R9", "load held by fence", int'(got), 0);
      mrdy = 1'b1;
      wait_rsp(20, got, rd, n);
      check(got && rd == init_val(8'hB1), "R9", "load data after fence", int'(rd), int'(init_val(8'hB1)));
      mrdy = 1'b0;
      chk_log(0, 1'b1, 8'hB0, 16'h7777, "R9");
      chk_log(1, 1'b0, 8'hB1, 16'h0, "R9");

      // R10 write-then-write fence in out-of-order mode
      do_reset(1'b1, 1'b0);
      push(8'hC0, 16'hC0C0, "R2");
      push(8'hC1, 16'hC1C1, "R2");
      drain_one();
      fence(1'b1);
      push(8'hC2, 16'hC2C2, "R2");
      mrdy = 1'b1;
      repeat (6) @(negedge clk);
      mrdy = 1'b0;
      chk_log(0, 1'b1, 8'hC0, 16'hC0C0, "R10");
      chk_log(1, 1'b1, 8'hC1, 16'hC1C1, "R10");
      chk_log(2, 1'b1, 8'hC2, 16'hC2C2, "R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule